// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block sits behind an instruction fetch path that delivers code as a stream of bytes, one per clock, under a valid/ready handshake. The first byte of each instruction carries an operation class in its high nibble and a sub-function in its low nibble. The class alone fixes how many bytes the instruction occupies (one, two, five or six). From the first byte the decoder knows how many more bytes to collect and where they belong.

Once the last byte of an instruction has been taken, the decoder presents one registered record on a second valid/ready handshake. The record holds the class, the sub-function, two register identifiers, a 32-bit constant assembled least-significant byte first, the instruction length, and an error flag for classes that are not defined. Fields that an instruction does not encode are reported as register ID 8, which means "no register", and as a zero constant. While a finished record waits for the consumer, the input side is stalled.

Top module: `ibyte_decoder`

## Requirements
- R1: In the cycle after a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first-byte high nibble (class) fixes the length. Classes 0 (halt), 1 (nop) and 9 (return) take 1 byte. Classes 2 (register move), 6 (ALU), A (push) and B (pop) take 2 bytes. Classes 7 (jump) and 8 (call) take 5 bytes. Classes 3 (immediate move), 4 (store) and 5 (load) take 6 bytes. The byte after the last one starts a new instruction.
- R3: `out_class` is bit 7..4 of the first byte and `out_func` is bit 3..0.
- R4: For classes 2 through 6, A and B, the second byte gives `out_ra` from bits 7..4 and `out_rb` from bits 3..0. For every other class, both report 8.
- R5: For classes 7 and 8, `out_const` is bytes 1..4 taken little-endian (byte 1 is bits 7..0). For classes 3, 4 and 5, it is bytes 2..5 taken the same way. For all other classes it is 0.
- R6: A class of C through F gives `out_bad`=1, length 1, `out_ra`=`out_rb`=8 and constant 0, and the instruction uses only one byte. Defined classes give `out_bad`=0.
- R7: While `out_valid` is 1 and `out_ready` is 0, the record stays unchanged and `in_ready` is 0.
- R8: `out_len` reports the byte count of the instruction in the record.
- R9: Cycles with `in_valid`=0 between the bytes of an instruction do not change the record.
- R10: The record is valid in the cycle after its last byte is accepted. While `out_ready` is 1, one byte is accepted every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 4 | Operation class |
| out_func | output | 4 | Sub-function |
| out_ra | output | 4 | First register ID (8 = none) |
| out_rb | output | 4 | Second register ID (8 = none) |
| out_const | output | 32 | Little-endian constant word |
| out_len | output | 3 | Instruction length in bytes |
| out_bad | output | 1 | Undefined class |

## Verification
The hardest case to reach is a record that is finished but held while the next byte is already waiting at the input. Input and output backpressure then meet, and the held record must stay frozen while `in_ready` stays low. The stimulus reaches this state by dropping `out_ready` and offering a one-byte instruction followed at once by the first byte of a register move. The bench holds this for several cycles, then releases `out_ready` and checks that both records come out in order. The bench also offers bytes of a six-byte move with idle gaps between them, and places an undefined class directly before a nop to show that only one byte was consumed.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  localparam logic [3:0] CL_HALT = 4'h0;
  localparam logic [3:0] CL_NOP  = 4'h1;
  localparam logic [3:0] CL_RR   = 4'h2;
  localparam logic [3:0] CL_IR   = 4'h3;
  localparam logic [3:0] CL_RM   = 4'h4;
  localparam logic [3:0] CL_MR   = 4'h5;
  localparam logic [3:0] CL_ALU  = 4'h6;
  localparam logic [3:0] CL_JMP  = 4'h7;
  localparam logic [3:0] CL_CALL = 4'h8;
  localparam logic [3:0] CL_RET  = 4'h9;
  localparam logic [3:0] CL_PUSH = 4'hA;
  localparam logic [3:0] CL_POP  = 4'hB;
  localparam logic [3:0] REG_NONE = 4'h8;

  // layout of the bytes that follow the first one
  typedef enum logic [1:0] {
    LAY_BARE = 2'd0,  // nothing follows
    LAY_REG  = 2'd1,  // register byte only
    LAY_DEST = 2'd2,  // constant only
    LAY_RC   = 2'd3   // register byte then constant
  } layout_e;

  function automatic layout_e layout_of(input logic [3:0] cls);
    case (cls)
      CL_RR, CL_ALU, CL_PUSH, CL_POP: layout_of = LAY_REG;
      CL_JMP, CL_CALL:                layout_of = LAY_DEST;
      CL_IR, CL_RM, CL_MR:            layout_of = LAY_RC;
      default:                        layout_of = LAY_BARE;
    endcase
  endfunction
endpackage

// File: rtl/ibd_fmt.sv
module ibd_fmt
  import ibd_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int LEN_W      = 3
) (
  input  logic [3:0]       cls,
  output layout_e          lay,
  output logic [LEN_W-1:0] len,
  output logic             bad
);
  always_comb begin
    bad = (cls > CL_POP);
    lay = layout_of(cls);
    case (lay)
      LAY_REG:  len = LEN_W'(2);
      LAY_DEST: len = LEN_W'(1 + WORD_BYTES);
      LAY_RC:   len = LEN_W'(2 + WORD_BYTES);
      default:  len = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/ibd_gather.sv
module ibd_gather
  import ibd_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int LEN_W      = 3,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [7:0]        byte_in,
  output logic              fin,
  output logic [3:0]        r_cls,
  output logic [3:0]        r_func,
  output logic [3:0]        r_ra,
  output logic [3:0]        r_rb,
  output logic [WORD_W-1:0] r_word,
  output logic [LEN_W-1:0]  r_len,
  output logic              r_bad
);
  layout_e          f_lay;
  logic [LEN_W-1:0] f_len;
  logic             f_bad;

  ibd_fmt #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_fmt (
    .cls(byte_in[7:4]), .lay(f_lay), .len(f_len), .bad(f_bad)
  );

  logic             busy, n_busy;
  logic [LEN_W-1:0] idx, n_idx;
  logic [3:0]       h_cls, h_func, h_ra, h_rb;
  layout_e          h_lay, n_lay;
  logic [LEN_W-1:0] h_len;
  logic [WORD_W-1:0] h_word;

  always_comb begin
    n_busy = busy;
    n_idx  = idx;
    n_lay  = h_lay;
    r_cls  = h_cls;
    r_func = h_func;
    r_ra   = h_ra;
    r_rb   = h_rb;
    r_word = h_word;
    r_len  = h_len;
    r_bad  = 1'b0;
    fin    = 1'b0;
    if (take) begin
      if (!busy) begin
        r_cls  = byte_in[7:4];
        r_func = byte_in[3:0];
        r_ra   = REG_NONE;
        r_rb   = REG_NONE;
        r_word = '0;
        r_len  = f_len;
        r_bad  = f_bad;
        n_lay  = f_lay;
        if (f_len == LEN_W'(1)) begin
          fin = 1'b1;
        end else begin
          n_busy = 1'b1;
          n_idx  = LEN_W'(1);
        end
      end else begin
        if ((h_lay == LAY_REG || h_lay == LAY_RC) && idx == LEN_W'(1)) begin
          r_ra = byte_in[7:4];
          r_rb = byte_in[3:0];
        end else begin
          r_word = {byte_in, h_word[WORD_W-1:8]};
        end
        if (idx + LEN_W'(1) == h_len) begin
          fin    = 1'b1;
          n_busy = 1'b0;
          n_idx  = '0;
        end else begin
          n_idx = idx + LEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      h_lay  <= LAY_BARE;
      h_cls  <= '0;
      h_func <= '0;
      h_ra   <= REG_NONE;
      h_rb   <= REG_NONE;
      h_word <= '0;
      h_len  <= LEN_W'(1);
    end else begin
      busy   <= n_busy;
      idx    <= n_idx;
      h_lay  <= n_lay;
      h_cls  <= r_cls;
      h_func <= r_func;
      h_ra   <= r_ra;
      h_rb   <= r_rb;
      h_word <= r_word;
      h_len  <= r_len;
    end
  end

  // R2: a partly gathered instruction always has bytes still to come
  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx != '0) && (idx < h_len));
  // R10: a record is only produced by an accepted byte
  a_r10_fin_on_take: assert property (@(posedge clk) disable iff (rst)
    fin |-> take);
endmodule

// File: rtl/ibd_outreg.sv
module ibd_outreg #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic [3:0]        d_cls,
  input  logic [3:0]        d_func,
  input  logic [3:0]        d_ra,
  input  logic [3:0]        d_rb,
  input  logic [WORD_W-1:0] d_word,
  input  logic [LEN_W-1:0]  d_len,
  input  logic              d_bad,
  input  logic              q_ready,
  output logic              q_valid,
  output logic [3:0]        q_cls,
  output logic [3:0]        q_func,
  output logic [3:0]        q_ra,
  output logic [3:0]        q_rb,
  output logic [WORD_W-1:0] q_word,
  output logic [LEN_W-1:0]  q_len,
  output logic              q_bad
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_cls   <= '0;
      q_func  <= '0;
      q_ra    <= '0;
      q_rb    <= '0;
      q_word  <= '0;
      q_len   <= '0;
      q_bad   <= 1'b0;
    end else if (fin) begin
      q_valid <= 1'b1;
      q_cls   <= d_cls;
      q_func  <= d_func;
      q_ra    <= d_ra;
      q_rb    <= d_rb;
      q_word  <= d_word;
      q_len   <= d_len;
      q_bad   <= d_bad;
    end else if (q_ready) begin
      q_valid <= 1'b0;
    end
  end

  // R7: a record that is not taken stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready) |=> q_valid && $stable(q_word) && $stable(q_cls)
      && $stable(q_ra) && $stable(q_rb) && $stable(q_len));
endmodule

// File: rtl/ibyte_decoder.sv
module ibyte_decoder
  import ibd_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int LEN_W     = $clog2(WORD_BYTES + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_class,
  output logic [3:0]        out_func,
  output logic [3:0]        out_ra,
  output logic [3:0]        out_rb,
  output logic [WORD_W-1:0] out_const,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_bad
);
  logic              take, fin;
  logic [3:0]        g_cls, g_func, g_ra, g_rb;
  logic [WORD_W-1:0] g_word;
  logic [LEN_W-1:0]  g_len;
  logic              g_bad;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  ibd_gather #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_gather (
    .clk(clk), .rst(rst), .take(take), .byte_in(in_byte), .fin(fin),
    .r_cls(g_cls), .r_func(g_func), .r_ra(g_ra), .r_rb(g_rb),
    .r_word(g_word), .r_len(g_len), .r_bad(g_bad)
  );

  ibd_outreg #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst(rst), .fin(fin),
    .d_cls(g_cls), .d_func(g_func), .d_ra(g_ra), .d_rb(g_rb),
    .d_word(g_word), .d_len(g_len), .d_bad(g_bad),
    .q_ready(out_ready), .q_valid(out_valid),
    .q_cls(out_class), .q_func(out_func), .q_ra(out_ra), .q_rb(out_rb),
    .q_word(out_const), .q_len(out_len), .q_bad(out_bad)
  );

  // R1: nothing is presented right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
  // R6: an undefined class is a single byte with no operands
  a_r6_bad_short: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bad) |-> (out_len == LEN_W'(1)) && (out_class > CL_POP)
      && (out_ra == REG_NONE) && (out_rb == REG_NONE));
  // R4: jump and call carry no register byte
  a_r4_dest_noreg: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_class == CL_JMP || out_class == CL_CALL))
      |-> (out_ra == REG_NONE) && (out_rb == REG_NONE));
  // R5: one-byte instructions carry no constant
  a_r5_short_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == LEN_W'(1)) |-> (out_const == '0));
endmodule

// File: tb/ibyte_decoder_test.sv
module ibyte_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_class, out_func, out_ra, out_rb;
  logic [31:0] out_const;
  logic [2:0]  out_len;
  logic        out_bad;

  int total = 0;
  int bad = 0;
  logic [51:0] recq[$];

  always #5 clk = ~clk;

  ibyte_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_func(out_func), .out_ra(out_ra),
    .out_rb(out_rb), .out_const(out_const), .out_len(out_len),
    .out_bad(out_bad)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready)
      recq.push_back({out_class, out_func, out_ra, out_rb, out_const, out_len, out_bad});

  function automatic logic [51:0] mk(input logic [3:0] c, input logic [3:0] f,
      input logic [3:0] a, input logic [3:0] b, input logic [31:0] w,
      input logic [2:0] l, input logic e);
    return {c, f, a, b, w, l, e};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_rec(input string req, input logic [51:0] exp);
    if (recq.size() == 0) check(req, 64'hDEAD, {12'h0, exp});
    else begin
      logic [51:0] got;
      got = recq.pop_front();
      check(req, {12'h0, got}, {12'h0, exp});
    end
  endtask

  // drive from just after a rising edge; returns just after the accepting edge
  task automatic put(input logic [7:0] b);
    logic acc;
    in_valid = 1'b1;
    in_byte  = b;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    check("R1 in_ready", {63'h0, in_ready}, 64'h1);
  endtask

  task automatic t_short;
    put(8'h00); put(8'h1F); put(8'h92);
    idle(2);
    expect_rec("R2 R3 halt", mk(4'h0, 4'h0, 4'h8, 4'h8, 0, 3'd1, 1'b0));
    expect_rec("R3 R4 nop", mk(4'h1, 4'hF, 4'h8, 4'h8, 0, 3'd1, 1'b0));
    expect_rec("R5 R8 ret", mk(4'h9, 4'h2, 4'h8, 4'h8, 0, 3'd1, 1'b0));
  endtask

  task automatic t_two;
    put(8'h20); put(8'h31);
    put(8'h61); put(8'h45);
    put(8'hA0); put(8'h58);
    put(8'hB0); put(8'h78);
    idle(2);
    expect_rec("R4 rrmove", mk(4'h2, 4'h0, 4'h3, 4'h1, 0, 3'd2, 1'b0));
    expect_rec("R4 alu", mk(4'h6, 4'h1, 4'h4, 4'h5, 0, 3'd2, 1'b0));
    expect_rec("R2 push", mk(4'hA, 4'h0, 4'h5, 4'h8, 0, 3'd2, 1'b0));
    expect_rec("R8 pop", mk(4'hB, 4'h0, 4'h7, 4'h8, 0, 3'd2, 1'b0));
  endtask

  task automatic t_five;
    put(8'h73); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
    put(8'h80); put(8'h01); put(8'h00); put(8'h00); put(8'h80);
    idle(2);
    expect_rec("R5 jump dest", mk(4'h7, 4'h3, 4'h8, 4'h8, 32'h12345678, 3'd5, 1'b0));
    expect_rec("R5 call dest", mk(4'h8, 4'h0, 4'h8, 4'h8, 32'h80000001, 3'd5, 1'b0));
  endtask

  task automatic t_six;
    put(8'h30); put(8'h8F); put(8'hEF); put(8'hBE); put(8'hAD); put(8'hDE);
    put(8'h40); put(8'h12); put(8'h04); put(8'h03); put(8'h02); put(8'h01);
    put(8'h50); put(8'h67); put(8'hFF); put(8'h00); put(8'h00); put(8'h00);
    idle(2);
    expect_rec("R5 immove", mk(4'h3, 4'h0, 4'h8, 4'hF, 32'hDEADBEEF, 3'd6, 1'b0));
    expect_rec("R5 store", mk(4'h4, 4'h0, 4'h1, 4'h2, 32'h01020304, 3'd6, 1'b0));
    expect_rec("R2 load", mk(4'h5, 4'h0, 4'h6, 4'h7, 32'h000000FF, 3'd6, 1'b0));
  endtask

  task automatic t_invalid;
    put(8'hC5); put(8'hF0); put(8'h10);
    idle(2);
    expect_rec("R6 class C", mk(4'hC, 4'h5, 4'h8, 4'h8, 0, 3'd1, 1'b1));
    expect_rec("R6 class F", mk(4'hF, 4'h0, 4'h8, 4'h8, 0, 3'd1, 1'b1));
    expect_rec("R6 one byte used", mk(4'h1, 4'h0, 4'h8, 4'h8, 0, 3'd1, 1'b0));
  endtask

  task automatic t_gaps;
    put(8'h30); idle(3); put(8'h82); idle(1); put(8'h11);
    idle(4); put(8'h22); put(8'h33); idle(2); put(8'h44);
    idle(2);
    expect_rec("R9 gaps", mk(4'h3, 4'h0, 4'h8, 4'h2, 32'h44332211, 3'd6, 1'b0));
  endtask

  task automatic t_backpressure;
    out_ready = 1'b0;
    put(8'h10);
    in_valid = 1'b1;
    in_byte  = 8'h20;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 held valid", {63'h0, out_valid}, 64'h1);
      check("R7 in_ready low", {63'h0, in_ready}, 64'h0);
      check("R7 held class", {60'h0, out_class}, 64'h1);
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 released", {63'h0, in_ready}, 64'h1);
    @(posedge clk); #1;
    put(8'h44);
    idle(2);
    expect_rec("R7 first", mk(4'h1, 4'h0, 4'h8, 4'h8, 0, 3'd1, 1'b0));
    expect_rec("R7 second", mk(4'h2, 4'h0, 4'h4, 4'h4, 0, 3'd2, 1'b0));
  endtask

  task automatic t_latency;
    time t0;
    put(8'h10);
    @(negedge clk);
    check("R10 next-cycle valid", {63'h0, out_valid}, 64'h1);
    @(posedge clk); #1;
    t0 = $time;
    put(8'h10); put(8'h10); put(8'h10);
    check("R10 one byte per cycle", 64'($time - t0), 64'd30);
    idle(2);
    for (int i = 0; i < 4; i++)
      expect_rec("R10 stream", mk(4'h1, 4'h0, 4'h8, 4'h8, 0, 3'd1, 1'b0));
    check("R10 no extra", 64'(recq.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    @(posedge clk); #1;
    t_short();
    t_two();
    t_five();
    t_six();
    t_invalid();
    t_gaps();
    t_backpressure();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule